// File: doc/BRIEF.md
# Adaptive Write-Cycle Delay Tuner

This block holds the wait time that a serial EEPROM controller inserts after each page write, and tunes it from what the bus later reports. After every addressing attempt the controller pulses a strobe and supplies the number of acknowledge-polling retries that attempt needed. Any retry means the last wait was too short, so the wait grows. No retries means the wait was long enough, so the wait shrinks.

The amount of each change is a step size, which the block also keeps. A signed direction register records whether the previous result was too short or long enough. While results keep pointing the same way the step roughly doubles. When the direction reverses the step roughly halves, so the wait settles close to the shortest value that still avoids retries. After a long unbroken run of good results the step is nudged upward on every further good result, so the block probes downward again. The I2C signalling and the timer that counts out the wait belong to the controller.

Top module: `wdt_tuner`

## Requirements
- R1: A synchronous active-low reset sets the wait to 4000 us, the step to 128 and the direction to neutral (0).
- R2: Wait and step change only in the clock cycle after a strobe. Each strobe causes exactly one update, and both outputs are registers that hold their value between strobes.
- R3: On a strobe with a nonzero retry count and a step below 4, the step rises by one and the new step is added to the wait. The direction does not change.
- R4: On a strobe with retries, a step of 4 or more and a direction of +1, the step becomes twice the step minus one. The new step is added to the wait.
- R5: On a strobe with retries, a step of 4 or more and a negative direction, the old step is added to the wait. If the old step is above 1, the step becomes half the old step (rounded down) minus one. The direction becomes +1.
- R6: On a strobe with retries, a step of 4 or more and a neutral direction, wait and step stay as they are and the direction becomes +1.
- R7: On a strobe with a zero retry count and a negative direction, a step above 1 becomes twice the step minus one. This new step is subtracted from the wait.
- R8: On a strobe with a zero retry count and a direction of +1, the old step is subtracted from the wait. A step above 1 then becomes half the old step minus one. The direction is set to -1 and then takes part in the countdown of R9.
- R9: On every good result the direction decrements by one until it reaches -100. A good result that finds the direction already at -100 leaves it there and adds one to the step, after any other change to the step.
- R10: The wait never exceeds 10000 us and the step never exceeds 8191. Additions saturate at these limits.
- R11: A subtraction from the wait is skipped when the wait is not larger than the step, so the wait never falls below 1 us.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_stb | input | 1 | One-cycle pulse: one addressing result is ready |
| retry_cnt | input | 4 | Polling retries the attempt needed; 0 means the wait was long enough |
| delay_us | output | 14 | Current post-write wait in microseconds |
| step_us | output | 14 | Current adjustment step in microseconds |

## Verification
The scoreboard feeds the tuner four kinds of result sequences. A retry from the neutral state shows that R6 makes no change. Runs of retries separate the doubling of R4 from the saturation of R10. Alternating retry and good results walk the step down through the reversal rules of R5 and R8 into the small-step increment of R3. A run of more than a hundred good results separates the doubling of R7, the subtraction skip of R11 once the step passes the wait, and the floor nudge of R9. Idle stretches between strobes show that the outputs hold.

// File: rtl/wdt_tuner_pkg.sv
// Package: shared types for the write-cycle delay tuner.
// Assumes the direction register fits in DIR_W signed bits.
package wdt_tuner_pkg;

    localparam int DIR_W = 8;

    typedef logic signed [DIR_W-1:0] dir_t;

    // Update rule selected for one strobe
    typedef enum logic [2:0] {
        PATH_SMALL   = 3'd0,  // retry, tiny step
        PATH_RAISE   = 3'd1,  // retry, was already too short
        PATH_FLIP_UP = 3'd2,  // retry, was long enough before
        PATH_NEU_UP  = 3'd3,  // retry, neutral
        PATH_SHRINK  = 3'd4,  // good, was long enough before
        PATH_FLIP_DN = 3'd5,  // good, was too short before
        PATH_NEU_DN  = 3'd6   // good, neutral
    } path_e;

endpackage

// File: rtl/wdt_tuner_decide.sv
// Module: wdt_tuner_decide
// Picks which update rule applies from the retry count, the step size
// and the sign of the direction register. Purely combinational.
module wdt_tuner_decide
    import wdt_tuner_pkg::*;
#(
    parameter int RETRY_W   = 4,
    parameter int STEP_W    = 14,
    parameter int SMALL_LIM = 4
) (
    input  logic [RETRY_W-1:0] retry_cnt,
    input  logic [STEP_W-1:0]  step_q,
    input  dir_t               dir_q,
    output path_e              path
);

    logic retried;
    logic small_step;

    assign retried    = (retry_cnt != '0);
    assign small_step = (int'(step_q) < SMALL_LIM);

    // Rule selection: retries first by step size, then by direction
    always_comb begin
        if (retried) begin
            if (small_step)          path = PATH_SMALL;
            else if (dir_q > 0)      path = PATH_RAISE;
            else if (dir_q < 0)      path = PATH_FLIP_UP;
            else                     path = PATH_NEU_UP;
        end else begin
            if (dir_q < 0)           path = PATH_SHRINK;
            else if (dir_q > 0)      path = PATH_FLIP_DN;
            else                     path = PATH_NEU_DN;
        end
    end

endmodule

// File: rtl/wdt_tuner_arith.sv
// Module: wdt_tuner_arith
// Computes the next wait, step and direction for a chosen rule.
// Assumes DLY_W and STEP_W are at most 30 so 32-bit intermediates hold
// doubled and summed values without wrap. All results saturate.
module wdt_tuner_arith
    import wdt_tuner_pkg::*;
#(
    parameter int DLY_W     = 14,
    parameter int STEP_W    = 14,
    parameter int DLY_MAX   = 10000,
    parameter int STEP_MAX  = 8191,
    parameter int DIR_FLOOR = 100
) (
    input  path_e              path,
    input  logic [DLY_W-1:0]   dly_q,
    input  logic [STEP_W-1:0]  step_q,
    input  dir_t               dir_q,
    output logic [DLY_W-1:0]   dly_d,
    output logic [STEP_W-1:0]  step_d,
    output dir_t               dir_d
);

    localparam logic [31:0] DMAX = 32'(DLY_MAX);
    localparam logic [31:0] SMAX = 32'(STEP_MAX);

    // Saturate a step value at the step ceiling
    function automatic logic [31:0] clamp_step(input logic [31:0] v);
        return (v > SMAX) ? SMAX : v;
    endfunction

    logic [31:0] d_cur, s_cur, d_nx, s_nx;
    int          dir_nx;
    logic        good;

    assign d_cur = 32'(dly_q);
    assign s_cur = 32'(step_q);

    // Rule arithmetic, followed by the good-result countdown
    always_comb begin
        d_nx   = d_cur;
        s_nx   = s_cur;
        dir_nx = int'(dir_q);
        good   = 1'b0;
        case (path)
            PATH_SMALL: begin
                s_nx = clamp_step(s_cur + 32'd1);
                d_nx = d_cur + s_nx;
            end
            PATH_RAISE: begin
                s_nx = s_cur << 1;
                if (s_nx > 32'd2) s_nx = s_nx - 32'd1;
                s_nx   = clamp_step(s_nx);
                d_nx   = d_cur + s_nx;
                dir_nx = 1;
            end
            PATH_FLIP_UP: begin
                d_nx = d_cur + s_cur;
                if (s_cur > 32'd1) s_nx = (s_cur >> 1) - 32'd1;
                dir_nx = 1;
            end
            PATH_NEU_UP: begin
                dir_nx = 1;
            end
            PATH_SHRINK: begin
                if (s_cur > 32'd1) s_nx = clamp_step((s_cur << 1) - 32'd1);
                if (d_cur > s_nx) d_nx = d_cur - s_nx;
                good = 1'b1;
            end
            PATH_FLIP_DN: begin
                if (d_cur > s_cur) d_nx = d_cur - s_cur;
                if (s_cur > 32'd1) s_nx = (s_cur >> 1) - 32'd1;
                dir_nx = -1;
                good   = 1'b1;
            end
            default: begin
                good = 1'b1;
            end
        endcase
        if (good) begin
            if (dir_nx > -DIR_FLOOR) dir_nx = dir_nx - 1;
            else                     s_nx   = clamp_step(s_nx + 32'd1);
        end
        if (d_nx > DMAX) d_nx = DMAX;
    end

    // Narrow the results to register widths
    always_comb begin
        dly_d  = d_nx[DLY_W-1:0];
        step_d = s_nx[STEP_W-1:0];
        dir_d  = dir_nx[DIR_W-1:0];
    end

endmodule

// File: rtl/wdt_tuner_regs.sv
// Module: wdt_tuner_regs
// State registers of the tuner. Loads the computed next state once per
// strobe; synchronous active-low reset to the initial operating point.
module wdt_tuner_regs
    import wdt_tuner_pkg::*;
#(
    parameter int DLY_W     = 14,
    parameter int STEP_W    = 14,
    parameter int DLY_INIT  = 4000,
    parameter int STEP_INIT = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [DLY_W-1:0]   dly_d,
    input  logic [STEP_W-1:0]  step_d,
    input  dir_t               dir_d,
    output logic [DLY_W-1:0]   dly_q,
    output logic [STEP_W-1:0]  step_q,
    output dir_t               dir_q
);

    // Hold state, update only on a strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_q  <= DLY_W'(DLY_INIT);
            step_q <= STEP_W'(STEP_INIT);
            dir_q  <= '0;
        end else if (load) begin
            dly_q  <= dly_d;
            step_q <= step_d;
            dir_q  <= dir_d;
        end
    end

endmodule

// File: rtl/wdt_tuner.sv
// Module: wdt_tuner (top)
// Adaptive post-write delay tuner. Each strobe carries a retry count from
// one addressing attempt; the block lengthens or shortens the wait and
// adapts its step. Assumes upd_stb is a single-cycle pulse per result.
module wdt_tuner
    import wdt_tuner_pkg::*;
#(
    parameter int RETRY_W   = 4,
    parameter int DLY_W     = 14,
    parameter int STEP_W    = 14,
    parameter int DLY_INIT  = 4000,
    parameter int DLY_MAX   = 10000,
    parameter int STEP_INIT = 128,
    parameter int STEP_MAX  = 8191,
    parameter int DIR_FLOOR = 100,
    parameter int SMALL_LIM = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd_stb,
    input  logic [RETRY_W-1:0] retry_cnt,
    output logic [DLY_W-1:0]   delay_us,
    output logic [STEP_W-1:0]  step_us
);

    path_e              path;
    logic [DLY_W-1:0]   dly_q, dly_d;
    logic [STEP_W-1:0]  step_q, step_d;
    dir_t               dir_q, dir_d;

    wdt_tuner_decide #(
        .RETRY_W  (RETRY_W),
        .STEP_W   (STEP_W),
        .SMALL_LIM(SMALL_LIM)
    ) u_decide (
        .retry_cnt(retry_cnt),
        .step_q   (step_q),
        .dir_q    (dir_q),
        .path     (path)
    );

    wdt_tuner_arith #(
        .DLY_W    (DLY_W),
        .STEP_W   (STEP_W),
        .DLY_MAX  (DLY_MAX),
        .STEP_MAX (STEP_MAX),
        .DIR_FLOOR(DIR_FLOOR)
    ) u_arith (
        .path  (path),
        .dly_q (dly_q),
        .step_q(step_q),
        .dir_q (dir_q),
        .dly_d (dly_d),
        .step_d(step_d),
        .dir_d (dir_d)
    );

    wdt_tuner_regs #(
        .DLY_W    (DLY_W),
        .STEP_W   (STEP_W),
        .DLY_INIT (DLY_INIT),
        .STEP_INIT(STEP_INIT)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (upd_stb),
        .dly_d (dly_d),
        .step_d(step_d),
        .dir_d (dir_d),
        .dly_q (dly_q),
        .step_q(step_q),
        .dir_q (dir_q)
    );

    assign delay_us = dly_q;
    assign step_us  = step_q;

endmodule

// File: rtl/wdt_tuner_chk.sv
// Module: wdt_tuner_chk
// Port-level properties of the tuner, bound onto every wdt_tuner instance.
module wdt_tuner_chk #(
    parameter int RETRY_W   = 4,
    parameter int DLY_W     = 14,
    parameter int STEP_W    = 14,
    parameter int DLY_INIT  = 4000,
    parameter int DLY_MAX   = 10000,
    parameter int STEP_INIT = 128,
    parameter int STEP_MAX  = 8191
) (
    input logic               clk,
    input logic               rst_n,
    input logic               upd_stb,
    input logic [RETRY_W-1:0] retry_cnt,
    input logic [DLY_W-1:0]   delay_us,
    input logic [STEP_W-1:0]  step_us
);

    AST_RESET_POINT: assert property (@(posedge clk)
        !rst_n |=> (int'(delay_us) == DLY_INIT && int'(step_us) == STEP_INIT)); // R1

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_stb && $past(rst_n)) |=> ($stable(delay_us) && $stable(step_us))); // R2

    AST_RETRY_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_stb && retry_cnt != '0) |=> (delay_us >= $past(delay_us))); // R3

    AST_GOOD_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_stb && retry_cnt == '0) |=> (delay_us <= $past(delay_us))); // R7

    AST_DLY_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        int'(delay_us) <= DLY_MAX && int'(step_us) <= STEP_MAX); // R10

    AST_DLY_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        delay_us != '0); // R11

endmodule

bind wdt_tuner wdt_tuner_chk #(
    .RETRY_W  (RETRY_W),
    .DLY_W    (DLY_W),
    .STEP_W   (STEP_W),
    .DLY_INIT (DLY_INIT),
    .DLY_MAX  (DLY_MAX),
    .STEP_INIT(STEP_INIT),
    .STEP_MAX (STEP_MAX)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_stb  (upd_stb),
    .retry_cnt(retry_cnt),
    .delay_us (delay_us),
    .step_us  (step_us)
);

// File: tb/wdt_tuner_tb_top.sv
// Scoreboard bench: the driver predicts each update and queues it; the
// monitor compares after the edge that consumes each strobe.
module wdt_tuner_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_stb = 1'b0;
    logic [3:0]  retry_cnt = '0;
    logic [13:0] delay_us, step_us;

    int n_chk = 0;
    int n_bad = 0;
    int mdly, mstep, mdir;

    int    q_dly[$];
    int    q_step[$];
    string q_tag[$];

    always #5 clk = ~clk;

    wdt_tuner dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_stb  (upd_stb),
        .retry_cnt(retry_cnt),
        .delay_us (delay_us),
        .step_us  (step_us)
    );

    function automatic int cs(input int v);
        return (v > 8191) ? 8191 : v;
    endfunction

    task automatic check(input string tag, input int act_d, input int act_s,
                         input int exp_d, input int exp_s);
        n_chk++;
        if (act_d != exp_d || act_s != exp_s) begin
            n_bad++;
            $display("FAIL %s: delay=%0d step=%0d expected delay=%0d step=%0d",
                     tag, act_d, act_s, exp_d, exp_s);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        mdly = 4000; mstep = 128; mdir = 0;
        check("R1 reset", int'(delay_us), int'(step_us), 4000, 128);
    endtask

    // Driver: predict one update, queue it, pulse the strobe
    task automatic apply(input int r);
        string tag;
        bit    good;
        int    s0;
        tag  = "";
        good = 1'b0;
        s0   = mstep;
        if (r != 0) begin
            if (mstep < 4) begin
                mstep = cs(mstep + 1); mdly = mdly + mstep; tag = "R3";
            end else if (mdir > 0) begin
                mstep = cs(2 * mstep - 1); mdly = mdly + mstep; mdir = 1; tag = "R4";
            end else if (mdir < 0) begin
                mdly = mdly + mstep;
                if (mstep > 1) mstep = mstep / 2 - 1;
                mdir = 1; tag = "R5";
            end else begin
                mdir = 1; tag = "R6";
            end
            if (mdly > 10000) begin mdly = 10000; tag = "R10"; end
        end else begin
            good = 1'b1;
            if (mdir < 0) begin
                if (mstep > 1) mstep = cs(2 * mstep - 1);
                if (mdly > mstep) mdly = mdly - mstep; else tag = "R11";
                if (tag == "") tag = "R7";
            end else if (mdir > 0) begin
                if (mdly > mstep) mdly = mdly - mstep; else tag = "R11";
                if (mstep > 1) mstep = mstep / 2 - 1;
                mdir = -1;
                if (tag == "") tag = "R8";
            end else begin
                tag = "R9 neutral";
            end
            if (mdir > -100) mdir = mdir - 1;
            else begin mstep = cs(mstep + 1); tag = "R9"; end
        end
        if (r != 0 && s0 >= 4 && 2 * s0 - 1 > 8191 && tag == "R4") tag = "R10 step";
        q_dly.push_back(mdly);
        q_step.push_back(mstep);
        q_tag.push_back(tag);
        @(negedge clk);
        upd_stb   = 1'b1;
        retry_cnt = 4'(r);
        @(negedge clk);
        upd_stb   = 1'b0;
        retry_cnt = '0;
    endtask

    // Monitor: after each consuming edge, pop and compare
    always begin
        @(posedge clk);
        if (rst_n && upd_stb) begin
            #2;
            if (q_dly.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R2: unexpected update, no prediction queued");
            end else begin
                check(q_tag.pop_front(), int'(delay_us), int'(step_us),
                      q_dly.pop_front(), q_step.pop_front());
            end
        end
    end

    task automatic idle_hold(input int n);
        repeat (n) @(negedge clk);
        check("R2 hold", int'(delay_us), int'(step_us), mdly, mstep);
    endtask

    initial begin
        do_reset();
        idle_hold(3);
        apply(1);               // R6 neutral retry
        apply(2);               // R4
        apply(0);               // R8 flip down
        apply(0);               // R7
        apply(3);               // R5 flip up
        idle_hold(4);
        for (int i = 0; i < 6; i++) apply(1);   // R4 into R10 saturation
        idle_hold(2);
        do_reset();
        apply(1);
        for (int i = 0; i < 4; i++) begin apply(0); apply(1); end
        apply(1);               // R3 small step
        apply(15);
        apply(1);
        for (int i = 0; i < 120; i++) apply(0); // R7, R11, R9
        idle_hold(3);
        repeat (3) @(negedge clk);
        if (q_dly.size() != 0) begin
            n_chk++; n_bad++;
            $display("FAIL R2: %0d updates missing, expected 0", q_dly.size());
        end
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule